// File: doc/BRIEF.md
# Bus-Mapped 16x16 Multiply-Accumulate Unit

This block is a multiplier that sits beside a small 16-bit processor on its register bus. Software stores a first operand at one of four addresses, and the address it uses picks the operation. Storing the second operand launches the operation. The 32-bit result is held in two 16-bit registers. A third register reports the overflow of an accumulating operation. The first operand and the selected operation stay in place, so a run of products that share one factor only needs a new second operand each time.

The arithmetic completes within the write cycle of the second operand. Read data is a combinational decode of the current register contents, so the processor can fetch the result on the very next bus cycle. Accumulating operations add the new product to the 32-bit result already held. The flag register is rewritten by every operation and never gathers carries over several operations.

Top module: `mac_periph`

## Requirements
- R1: An active-low reset clears both operands, the selected operation, both result halves and the flag register, so every address reads 0x0000.
- R2: A write to address 0, 1, 2 or 3 stores the first operand and selects the operation: 0 unsigned multiply, 1 signed multiply, 2 unsigned multiply-accumulate, 3 signed multiply-accumulate. Any of these four addresses reads back the first operand, and address 4 reads back the second operand.
- R3: A write to address 4 stores the second operand and starts the operation. Result bits 15:0 (address 5), bits 31:16 (address 6) and the flag (address 7) show the new values in the bus cycle after that write.
- R4: Unsigned multiply replaces the result with the unsigned product of the two operands and sets the flag to 0x0000.
- R5: Signed multiply replaces the result with the two's-complement product and sets the flag to 0xFFFF when that product is negative and to 0x0000 otherwise.
- R6: Unsigned multiply-accumulate adds the unsigned product to the held 32-bit result modulo 2^32. The flag becomes 0x0001 when the sum carries out of bit 31 and 0x0000 otherwise.
- R7: Signed multiply-accumulate adds the signed product to the held result taken as a signed 32-bit value. The low 32 bits of the 33-bit sum are kept, and the flag becomes 0xFFFF when the 33-bit sum is negative and 0x0000 otherwise.
- R8: A second-operand write that is not preceded by a new first-operand write reuses the last first operand and the last selected operation.
- R9: Each operation overwrites the flag. A carry from an earlier operation is not kept when a later operation does not produce one.
- R10: Writes to addresses 5, 6 and 7 are ignored. The result and flag registers keep their values.
- R11: The result and the flag change only on a second-operand write. A first-operand write leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for the current bus cycle |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |

## Verification
The assertions assume that the address and write data are stable and defined in every cycle where the strobe is high. They also assume that the strobe is never unknown, because a second-operand write is recognised from these inputs alone. The bench changes the bus inputs only on the falling clock edge and drives defined values at all times, including while the strobe is low. Because the bench walks its vectors in sequence without a reset between them, each accumulating check builds on a result that the previous vector left behind.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_UMAC = 2'd2,
    MODE_SMAC = 2'd3
  } mac_mode_e;

  localparam logic [ADDR_W-1:0] A_OP2    = 3'd4;
  localparam logic [ADDR_W-1:0] A_RES_LO = 3'd5;
  localparam logic [ADDR_W-1:0] A_RES_HI = 3'd6;
  localparam logic [ADDR_W-1:0] A_EXT    = 3'd7;
endpackage

// File: rtl/mac_addr_dec.sv
module mac_addr_dec
  import mac_pkg::*;
(
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              op1_wr_o,
  output logic              op2_wr_o,
  output mac_mode_e         mode_o
);
  // first-operand addresses lie below the second-operand address; low bits pick the mode
  always_comb begin
    op1_wr_o = wr_i && (addr_i < A_OP2);
    op2_wr_o = wr_i && (addr_i == A_OP2);
    mode_o   = mac_mode_e'(addr_i[1:0]);
  end
endmodule

// File: rtl/mac_arith.sv
module mac_arith
  import mac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  mac_mode_e           mode_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [2*DATA_W-1:0] acc_i,
  output logic [2*DATA_W-1:0] res_o,
  output logic [DATA_W-1:0]   ext_o
);
  localparam int RES_W = 2 * DATA_W;
  localparam int SUM_W = RES_W + 1;

  logic             sgn;
  logic             acc_en;
  logic [SUM_W-1:0] a_x, b_x, prod, acc_x, sum;

  always_comb begin
    sgn    = (mode_i == MODE_SMUL) || (mode_i == MODE_SMAC);
    acc_en = (mode_i == MODE_UMAC) || (mode_i == MODE_SMAC);
    // extend to SUM_W bits; the low SUM_W bits of the product are exact in both signednesses
    a_x    = {{(SUM_W-DATA_W){sgn & a_i[DATA_W-1]}}, a_i};
    b_x    = {{(SUM_W-DATA_W){sgn & b_i[DATA_W-1]}}, b_i};
    prod   = a_x * b_x;
    acc_x  = acc_en ? {sgn & acc_i[RES_W-1], acc_i} : '0;
    sum    = acc_x + prod;
    res_o  = sum[RES_W-1:0];
    ext_o  = sgn ? {DATA_W{sum[RES_W]}} : {{(DATA_W-1){1'b0}}, sum[RES_W]};
  end
endmodule

// File: rtl/mac_periph.sv
module mac_periph
  import mac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  localparam int RES_W = 2 * DATA_W;

  logic              op1_wr, op2_wr;
  mac_mode_e         mode_dec, mode_q;
  logic [DATA_W-1:0] op1_q, op2_q, ext_q, ext_nxt;
  logic [RES_W-1:0]  res_q, res_nxt;

  mac_addr_dec u_dec (
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .op1_wr_o (op1_wr),
    .op2_wr_o (op2_wr),
    .mode_o   (mode_dec)
  );

  // operand B taken straight from the bus so the result lands in the write cycle
  mac_arith #(.DATA_W(DATA_W)) u_arith (
    .mode_i (mode_q),
    .a_i    (op1_q),
    .b_i    (bus_wdata_i),
    .acc_i  (res_q),
    .res_o  (res_nxt),
    .ext_o  (ext_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op1_q  <= '0;
      op2_q  <= '0;
      mode_q <= MODE_UMUL;
      res_q  <= '0;
      ext_q  <= '0;
    end else begin
      if (op1_wr) begin
        op1_q  <= bus_wdata_i;
        mode_q <= mode_dec;
      end
      if (op2_wr) begin
        op2_q <= bus_wdata_i;
        res_q <= res_nxt;
        ext_q <= ext_nxt;
      end
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_OP2:    bus_rdata_o = op2_q;
      A_RES_LO: bus_rdata_o = res_q[DATA_W-1:0];
      A_RES_HI: bus_rdata_o = res_q[RES_W-1:DATA_W];
      A_EXT:    bus_rdata_o = ext_q;
      default:  bus_rdata_o = op1_q;
    endcase
  end

  assert_umul_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op2_wr && mode_q == MODE_UMUL) |=>
      (res_q == ({{DATA_W{1'b0}}, $past(op1_q)} * {{DATA_W{1'b0}}, $past(bus_wdata_i)}))
      && (ext_q == '0));

  assert_uext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op2_wr && mode_q == MODE_UMAC) |=> (ext_q[DATA_W-1:1] == '0));

  assert_sext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op2_wr && (mode_q == MODE_SMUL || mode_q == MODE_SMAC)) |=>
      (ext_q == '0 || ext_q == '1));

  assert_op1_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op1_wr |=> ($stable(op1_q) && $stable(mode_q)));

  assert_res_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op2_wr |=> ($stable(res_q) && $stable(ext_q)));
endmodule

// File: tb/mac_periph_tb.sv
module mac_periph_tb;
  localparam int CLK_NS = 20;
  localparam int NV     = 15;

  // {mode/addr[1:0], a, b, expected result[31:0], expected flag}
  localparam logic [81:0] VEC [NV] = '{
    {2'd0, 16'hFFFF, 16'hFFFF, 32'hFFFE0001, 16'h0000},  // R4
    {2'd1, 16'hFFFF, 16'h0003, 32'hFFFFFFFD, 16'hFFFF},  // R5
    {2'd1, 16'h7FFF, 16'h7FFF, 32'h3FFF0001, 16'h0000},  // R5
    {2'd1, 16'h8000, 16'h8000, 32'h40000000, 16'h0000},  // R5
    {2'd2, 16'hFFFF, 16'hFFFF, 32'h3FFE0001, 16'h0001},  // R6 carry
    {2'd2, 16'h0001, 16'h0002, 32'h3FFE0003, 16'h0000},  // R9 carry dropped
    {2'd3, 16'h8000, 16'h7FFF, 32'hFFFE8003, 16'hFFFF},  // R7
    {2'd3, 16'h0002, 16'h0000, 32'hFFFE8003, 16'hFFFF},  // R7
    {2'd1, 16'h8000, 16'h8000, 32'h40000000, 16'h0000},  // R5
    {2'd3, 16'h8000, 16'h8000, 32'h80000000, 16'h0000},  // R7 positive 33-bit sum
    {2'd3, 16'h8000, 16'h8000, 32'hC0000000, 16'hFFFF},  // R7 negative held acc
    {2'd0, 16'h1234, 16'h0010, 32'h00012340, 16'h0000},  // R4
    {2'd1, 16'h0005, 16'hFFFE, 32'hFFFFFFF6, 16'hFFFF},  // R5
    {2'd2, 16'h0000, 16'h1234, 32'hFFFFFFF6, 16'h0000},  // R9
    {2'd2, 16'h0001, 16'h000A, 32'h00000000, 16'h0001}   // R6 wrap
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  mac_periph u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 16'h0000;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic expect_res(input string req, input logic [31:0] r, input logic [15:0] e);
    logic [15:0] v;
    bus_read(3'd5, v); check(req, v, r[15:0]);
    bus_read(3'd6, v); check(req, v, r[31:16]);
    bus_read(3'd7, v); check(req, v, e);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      bus_read(i[2:0], v);
      check("R1 reset", v, 16'h0000);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus_write({1'b0, VEC[i][81:80]}, VEC[i][79:64]);
      bus_write(3'd4, VEC[i][63:48]);
      expect_res("R3 vector", VEC[i][47:16], VEC[i][15:0]);
    end

    // R2 operand readback through all four first-operand addresses
    bus_write(3'd0, 16'h0003);
    for (int i = 0; i < 4; i++) begin
      bus_read(i[2:0], v);
      check("R2 op1 readback", v, 16'h0003);
    end
    bus_write(3'd4, 16'h0005);
    bus_read(3'd4, v); check("R2 op2 readback", v, 16'h0005);
    expect_res("R4 3x5", 32'd15, 16'h0000);

    // R8 reuse of first operand and mode
    bus_write(3'd4, 16'h0007);
    expect_res("R8 reuse", 32'd21, 16'h0000);

    // R11 first-operand write leaves result alone
    bus_write(3'd3, 16'hFFFF);
    expect_res("R11 op1 write", 32'd21, 16'h0000);
    // R8 mode persists for signed accumulate: 21 + (-1*2) = 19
    bus_write(3'd4, 16'h0002);
    expect_res("R8 smac reuse", 32'd19, 16'h0000);
    bus_write(3'd4, 16'h0014);
    expect_res("R7 neg", 32'hFFFFFFFF, 16'hFFFF);

    // R10 read-only registers
    bus_write(3'd5, 16'h1111);
    bus_write(3'd6, 16'h2222);
    bus_write(3'd7, 16'h0000);
    expect_res("R10 read-only", 32'hFFFFFFFF, 16'hFFFF);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 8; i++) begin
      bus_read(i[2:0], v);
      check("R1 mid reset", v, 16'h0000);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // after reset mode is unsigned multiply with op1 = 0
    bus_write(3'd4, 16'h1234);
    expect_res("R1 mode after reset", 32'd0, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule